// File: doc/BRIEF.md
# NAND Channel Write Interleaving Scheduler

This block places page writes from a host-side request queue onto one shared byte-wide flash channel with several NAND dies on it. For each accepted request it selects a die that is not programming, owns the bus while it sends the write opcode, the page address, the page payload and the confirm opcode to that die, and then lets the bus go. The die then programs on its own. While it does, the scheduler is already loading the next free die. Each die's internal program time is stood in for by a counter loaded with a parameter, so simulation can use a short value in place of the nominal 200 µs.

Because a new request can be taken in the confirm cycle of the previous one, load phases for different dies follow each other with no idle cycle. The number of dies that can be kept busy in turn is set by the ratio of program time to load time. Completions are reported per die on a bit vector, one cycle wide, when that die's program time runs out.

Top module: `nws_wr_sched`

## Requirements
- R1: After reset `req_ready` is 1, `die_sel` and `done_vec` are all zero, and the first accepted write goes to die 0.
- R2: `req_ready` is 1 exactly when the bus is idle or in its confirm cycle and at least one die is neither programming nor being loaded; otherwise it is 0 and requests wait.
- R3: While the bus carries a write, `die_sel` has exactly one bit set, the owning die; in every other cycle `die_sel`, `bus_cmd`, `bus_addr` and `dat_take` are all 0.
- R4: Each write is, cycle by cycle: one cycle with `bus_cmd`=1 and `bus_dq`=0x80; ADDR_BYTES cycles with `bus_addr`=1 carrying `req_addr` lowest byte first; PAGE_BYTES cycles with `dat_take`=1 and `bus_dq` equal to `dat_byte`; one cycle with `bus_cmd`=1 and `bus_dq`=0x10. The die's program time starts at that confirm cycle.
- R5: The die for a new write is the first free die found counting upward (wrapping) from the die loaded last; a programming die is never selected.
- R6: Bit d of `done_vec` is 1 for exactly one cycle, PROG_CYCLES cycles after die d's confirm cycle; die d is free from the next cycle.
- R7: A request that is pending in a confirm cycle, with a free die, gets its opcode cycle in the very next cycle, with no gap on the bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A page write request is offered |
| req_ready | output | 1 | The request is taken at this edge if valid |
| req_addr | input | ADDR_BYTES*8 | Page address of the offered request |
| dat_byte | input | 8 | Payload byte supplied by the host while `dat_take` is 1 |
| dat_take | output | 1 | Payload cycle: `dat_byte` is on the bus |
| bus_dq | output | 8 | Shared channel data byte |
| bus_cmd | output | 1 | Bus carries an opcode (write or confirm) |
| bus_addr | output | 1 | Bus carries an address byte |
| die_sel | output | N_DIES | One-hot die enable of the bus owner |
| done_vec | output | N_DIES | Per-die completion pulse |

## Verification
The bench feeds a long run of requests with irregular gaps into four dies whose program time is just longer than four loads, so the picker faces wrap-around, skipped busy dies and full stalls. A picker that ignored busy state or restarted at die 0 would show a wrong `die_sel` on the opcode cycle. A ready signal that ignored the die being loaded would let two writes target the same die. A sequencer that dropped back to idle before taking the next request would leave a gap after a confirm. A timer off by one would move the completion pulse away from the cycle the bench computes from the confirm cycle.

// File: rtl/nws_pkg.sv
package nws_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CMD,
    PH_ADDR,
    PH_DATA,
    PH_CONF
  } phase_t;

  localparam logic [7:0] OP_PROG = 8'h80;
  localparam logic [7:0] OP_CONF = 8'h10;

  // First set bit of free, scanning upward from last+1 and wrapping.
  // Returns last when nothing is free.
  function automatic int unsigned rr_next(input logic [31:0] free,
                                          input int unsigned last,
                                          input int unsigned n);
    int unsigned idx;
    rr_next = last;
    for (int unsigned i = n; i >= 1; i--) begin
      idx = (last + i) % n;
      if (free[idx]) rr_next = idx;
    end
  endfunction

endpackage

// File: rtl/nws_rr_pick.sv
module nws_rr_pick
  import nws_pkg::*;
#(
  parameter int N_DIES = 4,
  localparam int IW = $clog2(N_DIES)
) (
  input  logic [N_DIES-1:0] free_vec,
  input  logic [IW-1:0]     last_die,
  output logic              any_free,
  output logic [IW-1:0]     pick
);

  assign any_free = |free_vec;
  assign pick     = IW'(rr_next(32'(free_vec), int'(last_die), N_DIES));

endmodule

// File: rtl/nws_die_timer.sv
module nws_die_timer #(
  parameter int PROG_CYCLES = 10000,
  localparam int CW = $clog2(PROG_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy,
  output logic done
);

  logic [CW-1:0] remain;

  always_ff @(posedge clk) begin
    if (!rst_n)              remain <= '0;
    else if (load)           remain <= CW'(PROG_CYCLES);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);
  assign done = (remain == CW'(1));

endmodule

// File: rtl/nws_loader.sv
module nws_loader
  import nws_pkg::*;
#(
  parameter int N_DIES     = 4,
  parameter int ADDR_BYTES = 3,
  parameter int PAGE_BYTES = 16,
  localparam int IW = $clog2(N_DIES),
  localparam int MAXB = (ADDR_BYTES > PAGE_BYTES) ? ADDR_BYTES : PAGE_BYTES,
  localparam int CW = $clog2(MAXB + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    accept,
  input  logic [IW-1:0]           pick,
  input  logic [ADDR_BYTES*8-1:0] req_addr,
  input  logic [7:0]              dat_byte,
  output phase_t                  phase,
  output logic [N_DIES-1:0]       die_sel,
  output logic [7:0]              bus_dq,
  output logic                    bus_cmd,
  output logic                    bus_addr,
  output logic                    dat_take
);

  phase_t                  ph;
  logic [CW-1:0]           cnt;
  logic [IW-1:0]           owner;
  logic [ADDR_BYTES*8-1:0] sreg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph    <= PH_IDLE;
      cnt   <= '0;
      owner <= '0;
      sreg  <= '0;
    end else begin
      case (ph)
        PH_IDLE, PH_CONF: begin
          if (accept) begin
            ph    <= PH_CMD;
            owner <= pick;
            sreg  <= req_addr;
          end else begin
            ph <= PH_IDLE;
          end
        end
        PH_CMD: begin
          ph  <= PH_ADDR;
          cnt <= '0;
        end
        PH_ADDR: begin
          sreg <= sreg >> 8;
          if (cnt == CW'(ADDR_BYTES - 1)) begin
            ph  <= PH_DATA;
            cnt <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_DATA: begin
          if (cnt == CW'(PAGE_BYTES - 1)) ph <= PH_CONF;
          else                             cnt <= cnt + 1'b1;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign phase    = ph;
  assign die_sel  = (ph == PH_IDLE) ? '0 : (N_DIES'(1) << owner);
  assign bus_cmd  = (ph == PH_CMD) || (ph == PH_CONF);
  assign bus_addr = (ph == PH_ADDR);
  assign dat_take = (ph == PH_DATA);

  always_comb begin
    case (ph)
      PH_CMD:  bus_dq = OP_PROG;
      PH_ADDR: bus_dq = sreg[7:0];
      PH_DATA: bus_dq = dat_byte;
      PH_CONF: bus_dq = OP_CONF;
      default: bus_dq = 8'h00;
    endcase
  end

endmodule

// File: rtl/nws_wr_sched.sv
module nws_wr_sched
  import nws_pkg::*;
#(
  parameter int N_DIES      = 4,
  parameter int ADDR_BYTES  = 3,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 10000,
  localparam int IW = $clog2(N_DIES)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_BYTES*8-1:0] req_addr,
  input  logic [7:0]              dat_byte,
  output logic                    dat_take,
  output logic [7:0]              bus_dq,
  output logic                    bus_cmd,
  output logic                    bus_addr,
  output logic [N_DIES-1:0]       die_sel,
  output logic [N_DIES-1:0]       done_vec
);

  // Named internal events, used by the bound checker.
  phase_t            phase;
  logic [N_DIES-1:0] busy_vec;
  logic [N_DIES-1:0] free_vec;
  logic              any_free;
  logic [IW-1:0]     pick;
  logic [IW-1:0]     last_q;
  logic              can_take;
  logic              accept;
  logic              ld_start;
  logic              prog_start;

  assign free_vec   = ~busy_vec & ~die_sel;
  assign can_take   = (phase == PH_IDLE) || (phase == PH_CONF);
  assign req_ready  = can_take && any_free;
  assign accept     = req_valid && req_ready;
  assign ld_start   = (phase == PH_CMD);
  assign prog_start = (phase == PH_CONF);

  always_ff @(posedge clk) begin
    if (!rst_n)      last_q <= IW'(N_DIES - 1);
    else if (accept) last_q <= pick;
  end

  nws_rr_pick #(.N_DIES(N_DIES)) u_pick (
    .free_vec (free_vec),
    .last_die (last_q),
    .any_free (any_free),
    .pick     (pick)
  );

  nws_loader #(
    .N_DIES     (N_DIES),
    .ADDR_BYTES (ADDR_BYTES),
    .PAGE_BYTES (PAGE_BYTES)
  ) u_load (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .pick     (pick),
    .req_addr (req_addr),
    .dat_byte (dat_byte),
    .phase    (phase),
    .die_sel  (die_sel),
    .bus_dq   (bus_dq),
    .bus_cmd  (bus_cmd),
    .bus_addr (bus_addr),
    .dat_take (dat_take)
  );

  for (genvar g = 0; g < N_DIES; g++) begin : g_die
    nws_die_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (prog_start && die_sel[g]),
      .busy  (busy_vec[g]),
      .done  (done_vec[g])
    );
  end

endmodule

// File: rtl/nws_wr_sched_chk.sv
module nws_wr_sched_chk #(
  parameter int N_DIES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              bus_cmd,
  input logic              bus_addr,
  input logic              dat_take,
  input logic              ld_start,
  input logic              prog_start,
  input logic [N_DIES-1:0] die_sel,
  input logic [N_DIES-1:0] busy_vec,
  input logic [N_DIES-1:0] done_vec
);

  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(die_sel));

  assert_bus_has_owner_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd || bus_addr || dat_take) |-> (die_sel != '0));

  assert_no_busy_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ld_start |-> ((die_sel & busy_vec) == '0));

  assert_prog_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> ((busy_vec & $past(die_sel)) != '0));

  assert_done_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_vec != '0) |=> ((busy_vec & $past(done_vec)) == '0));

  assert_stall_all_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy_vec) |-> !req_ready);

endmodule

bind nws_wr_sched nws_wr_sched_chk #(.N_DIES(N_DIES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .bus_cmd    (bus_cmd),
  .bus_addr   (bus_addr),
  .dat_take   (dat_take),
  .ld_start   (ld_start),
  .prog_start (prog_start),
  .die_sel    (die_sel),
  .busy_vec   (busy_vec),
  .done_vec   (done_vec)
);

// File: tb/nws_wr_sched_tb.sv
module nws_wr_sched_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N    = 4;
  localparam int AB   = 2;
  localparam int PB   = 4;
  localparam int PROG = 40;
  localparam int LAST = AB + PB + 1;
  localparam int NREQ = 24;
  localparam int INF  = 1 << 30;

  logic            clk = 0;
  logic            rst_n = 0;
  logic            req_valid = 0;
  logic            req_ready;
  logic [AB*8-1:0] req_addr = '0;
  logic [7:0]      dat_byte;
  logic            dat_take;
  logic [7:0]      bus_dq;
  logic            bus_cmd;
  logic            bus_addr;
  logic [N-1:0]    die_sel;
  logic [N-1:0]    done_vec;

  int cyc = 0;
  int n_checks = 0;
  int n_fail = 0;
  int nsent = 0;
  int wr_idx = 0;
  int n_done = 0;
  bit mon_en = 0;
  bit finished = 0;

  logic [AB*8-1:0] sent_addr [NREQ];
  int free_from [N];
  int conf_cyc  [N];
  int exp_last = N - 1;
  int owner = 0;
  int pos = 0;
  bit loading = 0;
  bit pend = 0;
  bit pend_conf = 0;
  logic [AB*8-1:0] cur_addr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] dat_of(input int c);
    return 8'((c * 37) ^ 165);
  endfunction
  assign dat_byte = dat_of(cyc);

  nws_wr_sched #(
    .N_DIES(N), .ADDR_BYTES(AB), .PAGE_BYTES(PB), .PROG_CYCLES(PROG)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .dat_byte(dat_byte), .dat_take(dat_take),
    .bus_dq(bus_dq), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .die_sel(die_sel), .done_vec(done_vec)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
               req, what, cyc, act, exp);
    end
  endtask

  // Monitor and reference model, sampled at the falling edge.
  always @(negedge clk) begin
    if (mon_en) begin
      int c;
      bit started;
      bit exp_ready;
      c = cyc;
      started = 0;
      if (loading && pos < LAST) begin
        pos++;
        check(die_sel == N'(1 << owner), "R3", "owner held", die_sel, 1 << owner);
        if (pos <= AB) begin
          check(bus_addr && !bus_cmd && !dat_take, "R4", "addr phase", bus_addr, 1);
          check(bus_dq == cur_addr[(pos-1)*8 +: 8], "R4", "addr byte",
                bus_dq, cur_addr[(pos-1)*8 +: 8]);
        end else if (pos <= AB + PB) begin
          check(dat_take && !bus_cmd && !bus_addr, "R4", "data phase", dat_take, 1);
          check(bus_dq == dat_of(c), "R4", "data byte", bus_dq, dat_of(c));
        end else begin
          check(bus_cmd && !bus_addr && !dat_take, "R4", "confirm phase", bus_cmd, 1);
          check(bus_dq == 8'h10, "R4", "confirm byte", bus_dq, 8'h10);
          free_from[owner] = c + PROG + 1;
          conf_cyc[owner]  = c;
        end
      end else begin
        loading = 0;
        if (die_sel != '0) begin
          int e;
          bit found;
          found = 0;
          e = exp_last;
          for (int off = 1; off <= N; off++) begin
            int d;
            d = (exp_last + off) % N;
            if (!found && free_from[d] <= c - 1) begin
              e = d;
              found = 1;
            end
          end
          check(found, "R5", "start with no free die", die_sel, 0);
          check(die_sel == N'(1 << e), "R5 R1", "round-robin die", die_sel, 1 << e);
          check(bus_cmd && bus_dq == 8'h80, "R4", "write opcode", bus_dq, 8'h80);
          check(wr_idx < nsent, "R2", "start without request", wr_idx, nsent);
          if (wr_idx < NREQ) cur_addr = sent_addr[wr_idx];
          wr_idx++;
          exp_last = e;
          owner = e;
          free_from[e] = INF;
          loading = 1;
          pos = 0;
          started = 1;
        end else begin
          check(!bus_cmd && !bus_addr && !dat_take, "R3", "idle bus quiet",
                {bus_cmd, bus_addr, dat_take}, 0);
        end
      end
      if (pend)
        check(started, pend_conf ? "R7" : "R2", "expected start", started, 1);
      exp_ready = 0;
      if (!loading || pos == LAST)
        for (int d = 0; d < N; d++)
          if (free_from[d] <= c) exp_ready = 1;
      check(req_ready == exp_ready, "R2", "ready", req_ready, exp_ready);
      pend = req_valid && exp_ready;
      pend_conf = loading && pos == LAST;
      for (int d = 0; d < N; d++) begin
        bit ed;
        ed = (c == conf_cyc[d] + PROG);
        if (ed || done_vec[d])
          check(done_vec[d] == ed, "R6", $sformatf("done die %0d", d), done_vec[d], ed);
        if (done_vec[d]) n_done++;
      end
    end
  end

  task automatic send(input logic [AB*8-1:0] a);
    req_valid = 1;
    req_addr  = a;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    sent_addr[nsent] = a;
    nsent++;
    @(posedge clk);
    #1;
    req_valid = 0;
  endtask

  initial begin
    for (int d = 0; d < N; d++) begin
      free_from[d] = 0;
      conf_cyc[d]  = -1000;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    check(die_sel == '0, "R1", "no die after reset", die_sel, 0);
    check(done_vec == '0, "R1", "no done after reset", done_vec, 0);
    mon_en = 1;
    @(posedge clk);
    #1;
    for (int k = 0; k < NREQ; k++) begin
      int g;
      g = (k % 5 == 0) ? (k * 13) % 50 : ((k % 7 == 3) ? 2 : 0);
      repeat (g) begin
        @(posedge clk);
        #1;
      end
      send(AB*8'((k * 40503 + 7) & 16'hFFFF));
    end
    repeat (PROG + LAST + 10) @(posedge clk);
    @(negedge clk);
    check(n_done == NREQ, "R6", "completion count", n_done, NREQ);
    check(wr_idx == NREQ, "R4", "write count", wr_idx, NREQ);
    check(req_ready == 1, "R2", "ready when drained", req_ready, 1);
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, actual %0d expected %0d writes",
               wr_idx, NREQ);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule